// File: doc/BRIEF.md
# DSI Video-Mode Packet Sequencer

This block produces the ordered list of packets that a display serial link master sends for each line of a video-mode frame. A vertical line counter walks the frame through its sync, back-porch, active and front-porch lines. A horizontal stepper walks each line through its packet slots. A planning stage decides which slots apply to the current line and builds the descriptor for the current slot.

Every descriptor carries three things: a data identifier made of the virtual channel and the packet type, a 16-bit word count, and a flag. The flag tells the downstream packer that the payload must be pulled from the pixel stream. Descriptors leave over a valid/ready handshake. Checksums, lane striping and the physical layer sit downstream of this block.

Configuration is applied while the `en` input is low. It must stay stable while the block runs.

Top module: `dsi_vid_pkt_seq`

## Requirements
- R1: During reset and while `en` is low, `pkt_valid` is 0. In the cycle after `en` is seen high, the first descriptor is a VSYNC start (type 0x01) for frame line 0. Lowering `en` and raising it again restarts the frame from that same packet.
- R2: Short packet types appear in `pkt_di[5:0]` with these codes: VSYNC start 0x01, VSYNC end 0x11, HSYNC start 0x21, HSYNC end 0x31, end of transmission 0x08. Every line opens with one start packet. Line 0 opens with 0x01. In normal vertical mode, the line whose index equals VSA opens with 0x11. Every other line opens with 0x21.
- R3: In normal vertical mode a frame has VSA sync lines, then VBP lines, then the active lines, then VFP lines. After the last front-porch line, the next line is line 0 of a new frame.
- R4: In auto vertical mode, VSA and VBP are ignored. The frame is the active lines followed by the VFP lines, and line 0 is active.
- R5: In sync-pulse mode an active line carries, in this order: start, HSA blanking, HSYNC end, HBP blanking, pixel packet, the optional null packet, HFP blanking, and the optional end-of-transmission packet. In sync-event mode, the HSA blanking and HSYNC end packets are left out.
- R6: In sync-pulse mode with the HSE option set, each vertical blanking line carries an HSYNC end packet right after its start packet. Without HSE, or in sync-event mode, blanking lines carry no HSYNC end packet.
- R7: The three skip bits each drop their own region: one drops the HSA blanking packet, one the HBP blanking packet, and one the HFP blanking packet. Each bit affects only its own region.
- R8: In non-burst mode, a null packet (type 0x09) follows the pixel packet on every active line. In burst mode, no null packet is sent.
- R9: Blanking packets use type 0x19. The word count of a blanking or null packet is the programmed region byte count minus 6, or 0 when the byte count is 6 or less. Short packets report a word count of 0.
- R10: The pixel packet type and word count depend on `cfg_fmt`, where H is the active width:
  - 0 gives 0x0E and 2·H bytes.
  - 1 gives 0x1E and ceil(9·H/4) bytes.
  - 2 gives 0x2E and 3·H bytes.
  - 3 gives 0x3E and 3·H bytes.

  `pkt_pix` is 1 only on pixel packets.
- R11: When `cfg_eot_off` is set, no 0x08 packet is produced. Otherwise every line ends with one.
- R12: `pkt_di[7:6]` always equals `cfg_vc`.
- R13: While `pkt_valid` is high and `pkt_ready` is low, the descriptor holds steady. The sequence advances by exactly one packet per accepted transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low parks the sequencer at frame start |
| cfg_vc | input | 2 | Virtual channel |
| cfg_fmt | input | 2 | Pixel format select |
| cfg_sync_pulse | input | 1 | 1 = sync-pulse, 0 = sync-event |
| cfg_burst | input | 1 | 1 = burst (no null padding) |
| cfg_hse | input | 1 | HSYNC end on vertical blanking lines |
| cfg_skip_hsa | input | 1 | Drop HSA blanking |
| cfg_skip_hbp | input | 1 | Drop HBP blanking |
| cfg_skip_hfp | input | 1 | Drop HFP blanking |
| cfg_eot_off | input | 1 | Suppress end-of-transmission packets |
| cfg_auto_vert | input | 1 | Auto vertical count mode |
| cfg_hsa | input | 16 | HSA region bytes |
| cfg_hbp | input | 16 | HBP region bytes |
| cfg_hfp | input | 16 | HFP region bytes |
| cfg_hpad | input | 16 | Null padding region bytes |
| cfg_hact | input | 11 | Active pixels per line |
| cfg_vsa | input | 10 | Vertical sync lines |
| cfg_vbp | input | 11 | Vertical back-porch lines |
| cfg_vfp | input | 11 | Vertical stable front-porch lines |
| cfg_vact | input | 11 | Active lines |
| pkt_valid | output | 1 | Descriptor valid |
| pkt_ready | input | 1 | Downstream accepts descriptor |
| pkt_di | output | 8 | Data identifier {vc, type} |
| pkt_wc | output | 16 | Word count |
| pkt_pix | output | 1 | Payload comes from pixel stream |

## Verification
- **Start-up timing:** a raised `en` is registered once, so the first descriptor shows up in the cycle after the edge that samples it.
- **Advance timing:** after each accepted transfer, the next descriptor is visible one edge later. When the last slot of a line is accepted, the line counter and the slot index change on that same edge.
- **Sampling discipline:** the bench drives `pkt_ready` and samples every output on the falling edge. A transfer is therefore recorded in the half cycle before the edge that takes it. A stalled descriptor is compared against its value one full cycle earlier.
- **Reference:** the expected packet list for a whole frame, plus the first packet of the next frame, is built in the bench from the requirements alone.

// File: rtl/dsi_vseq_pkg.sv
package dsi_vseq_pkg;

    // Configuration field widths
    localparam int HB_W   = 16;
    localparam int VSA_W  = 10;
    localparam int VP_W   = 11;
    localparam int RES_W  = 11;
    localparam int WC_W   = 16;
    localparam int VC_W   = 2;
    localparam int DT_W   = 6;
    localparam int LINE_W = VP_W + 2;   // holds VSA+VBP+VACT+VFP
    localparam int NUM_STEPS = 8;

    // Packet type codes (lower six bits of the identifier)
    localparam logic [DT_W-1:0] DT_VSS   = 6'h01;
    localparam logic [DT_W-1:0] DT_VSE   = 6'h11;
    localparam logic [DT_W-1:0] DT_HSS   = 6'h21;
    localparam logic [DT_W-1:0] DT_HSE   = 6'h31;
    localparam logic [DT_W-1:0] DT_EOT   = 6'h08;
    localparam logic [DT_W-1:0] DT_NULL  = 6'h09;
    localparam logic [DT_W-1:0] DT_BLANK = 6'h19;

    typedef enum logic [1:0] {
        LN_VSYNC  = 2'd0,
        LN_VBACK  = 2'd1,
        LN_ACTIVE = 2'd2,
        LN_VFRONT = 2'd3
    } line_kind_e;

    // Slot order within a line; the index order is the transmit order
    typedef enum logic [2:0] {
        STP_START = 3'd0,
        STP_HSA   = 3'd1,
        STP_HEND  = 3'd2,
        STP_HBP   = 3'd3,
        STP_PIX   = 3'd4,
        STP_NULL  = 3'd5,
        STP_HFP   = 3'd6,
        STP_EOT   = 3'd7
    } step_e;

    typedef struct packed {
        logic [VC_W-1:0] vc;
        logic [1:0]      fmt;
        logic            sync_pulse;
        logic            burst;
        logic            hse;
        logic            skip_hsa;
        logic            skip_hbp;
        logic            skip_hfp;
        logic            eot_off;
        logic [HB_W-1:0] hsa;
        logic [HB_W-1:0] hbp;
        logic [HB_W-1:0] hfp;
        logic [HB_W-1:0] hpad;
        logic [RES_W-1:0] hact;
    } hcfg_t;

    typedef struct packed {
        logic             auto_vert;
        logic [VSA_W-1:0] vsa;
        logic [VP_W-1:0]  vbp;
        logic [VP_W-1:0]  vfp;
        logic [RES_W-1:0] vact;
    } vcfg_t;

    typedef struct packed {
        logic [VC_W+DT_W-1:0] di;
        logic [WC_W-1:0]      wc;
        logic                 pix;
    } pkt_desc_t;

    // Region bytes minus header/checksum overhead, floored at zero
    function automatic logic [WC_W-1:0] blank_wc(input logic [HB_W-1:0] bytes);
        if (bytes > HB_W'(6))
            return WC_W'(bytes - HB_W'(6));
        return '0;
    endfunction

    function automatic logic [DT_W-1:0] pix_dt(input logic [1:0] fmt);
        case (fmt)
            2'd0:    return 6'h0E;
            2'd1:    return 6'h1E;
            2'd2:    return 6'h2E;
            default: return 6'h3E;
        endcase
    endfunction

    function automatic logic [WC_W-1:0] pix_wc(input logic [1:0] fmt,
                                                input logic [RES_W-1:0] hact);
        localparam int N_W = WC_W + 4;
        logic [N_W-1:0] n;
        n = N_W'(hact);
        case (fmt)
            2'd0:    n = n + n;
            2'd1:    n = ((n << 3) + n + N_W'(3)) >> 2;
            default: n = (n << 1) + n;
        endcase
        return n[WC_W-1:0];
    endfunction

endpackage

// File: rtl/dsi_vseq_lines.sv
module dsi_vseq_lines
    import dsi_vseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       advance,
    input  vcfg_t      vcfg,
    output line_kind_e kind,
    output logic       frame_start,
    output logic       vse_line
);

    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] b_sync, b_back, b_act, total;
    logic              last_line;

    always_comb begin
        b_sync = vcfg.auto_vert ? '0 : LINE_W'(vcfg.vsa);
        b_back = b_sync + (vcfg.auto_vert ? '0 : LINE_W'(vcfg.vbp));
        b_act  = b_back + LINE_W'(vcfg.vact);
        total  = b_act + LINE_W'(vcfg.vfp);
    end

    always_comb begin
        if (line_q < b_sync)      kind = LN_VSYNC;
        else if (line_q < b_back) kind = LN_VBACK;
        else if (line_q < b_act)  kind = LN_ACTIVE;
        else                      kind = LN_VFRONT;
    end

    assign last_line   = ((line_q + 1'b1) >= total);
    assign frame_start = (line_q == '0);
    assign vse_line    = !vcfg.auto_vert && (line_q == b_sync);

    always_ff @(posedge clk) begin
        if (rst || !run)
            line_q <= '0;
        else if (advance)
            line_q <= last_line ? '0 : line_q + 1'b1;
    end

    // R3: the line index never leaves the programmed frame
    p_line_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        (run && total != '0) |-> (line_q < total));

endmodule

// File: rtl/dsi_vseq_plan.sv
module dsi_vseq_plan
    import dsi_vseq_pkg::*;
(
    input  hcfg_t                  hcfg,
    input  line_kind_e             kind,
    input  logic                   frame_start,
    input  logic                   vse_line,
    input  step_e                  step,
    output logic [NUM_STEPS-1:0]   mask,
    output pkt_desc_t              desc
);

    logic            act;
    logic [DT_W-1:0] dt;

    assign act = (kind == LN_ACTIVE);

    // Which slots exist on the current line
    always_comb begin
        mask            = '0;
        mask[STP_START] = 1'b1;
        mask[STP_HSA]   = act && hcfg.sync_pulse && !hcfg.skip_hsa;
        mask[STP_HEND]  = hcfg.sync_pulse && (act || hcfg.hse);
        mask[STP_HBP]   = act && !hcfg.skip_hbp;
        mask[STP_PIX]   = act;
        mask[STP_NULL]  = act && !hcfg.burst;
        mask[STP_HFP]   = act && !hcfg.skip_hfp;
        mask[STP_EOT]   = !hcfg.eot_off;
    end

    // Descriptor for the current slot
    always_comb begin
        dt       = DT_HSS;
        desc.wc  = '0;
        desc.pix = 1'b0;
        case (step)
            STP_START: begin
                if (frame_start)   dt = DT_VSS;
                else if (vse_line) dt = DT_VSE;
                else               dt = DT_HSS;
            end
            STP_HSA: begin
                dt      = DT_BLANK;
                desc.wc = blank_wc(hcfg.hsa);
            end
            STP_HEND: dt = DT_HSE;
            STP_HBP: begin
                dt      = DT_BLANK;
                desc.wc = blank_wc(hcfg.hbp);
            end
            STP_PIX: begin
                dt       = pix_dt(hcfg.fmt);
                desc.wc  = pix_wc(hcfg.fmt, hcfg.hact);
                desc.pix = 1'b1;
            end
            STP_NULL: begin
                dt      = DT_NULL;
                desc.wc = blank_wc(hcfg.hpad);
            end
            STP_HFP: begin
                dt      = DT_BLANK;
                desc.wc = blank_wc(hcfg.hfp);
            end
            STP_EOT: dt = DT_EOT;
            default: dt = DT_HSS;
        endcase
        desc.di = {hcfg.vc, dt};
    end

endmodule

// File: rtl/dsi_vseq_step.sv
module dsi_vseq_step
    import dsi_vseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 fire,
    input  logic [NUM_STEPS-1:0] mask,
    output step_e                step,
    output logic                 line_done
);

    step_e step_q;
    step_e nxt_step;
    logic  nxt_found;

    // Lowest enabled slot above the current one
    always_comb begin
        nxt_found = 1'b0;
        nxt_step  = STP_START;
        for (int i = NUM_STEPS - 1; i >= 0; i--) begin
            if (i > int'(step_q) && mask[i]) begin
                nxt_found = 1'b1;
                nxt_step  = step_e'(3'(i));
            end
        end
    end

    assign line_done = fire && !nxt_found;
    assign step      = step_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            step_q <= STP_START;
        else if (fire)
            step_q <= nxt_found ? nxt_step : STP_START;
    end

    // R5: the slot being offered is always one the planner enabled
    p_step_enabled_r5: assert property (@(posedge clk) disable iff (rst)
        run |-> mask[step_q]);

    // R13: without a transfer the slot does not move
    p_step_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (run && !fire) |=> (!run || $stable(step_q)));

endmodule

// File: rtl/dsi_vid_pkt_seq.sv
module dsi_vid_pkt_seq
    import dsi_vseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [1:0]  cfg_vc,
    input  logic [1:0]  cfg_fmt,
    input  logic        cfg_sync_pulse,
    input  logic        cfg_burst,
    input  logic        cfg_hse,
    input  logic        cfg_skip_hsa,
    input  logic        cfg_skip_hbp,
    input  logic        cfg_skip_hfp,
    input  logic        cfg_eot_off,
    input  logic        cfg_auto_vert,
    input  logic [15:0] cfg_hsa,
    input  logic [15:0] cfg_hbp,
    input  logic [15:0] cfg_hfp,
    input  logic [15:0] cfg_hpad,
    input  logic [10:0] cfg_hact,
    input  logic [9:0]  cfg_vsa,
    input  logic [10:0] cfg_vbp,
    input  logic [10:0] cfg_vfp,
    input  logic [10:0] cfg_vact,
    output logic        pkt_valid,
    input  logic        pkt_ready,
    output logic [7:0]  pkt_di,
    output logic [15:0] pkt_wc,
    output logic        pkt_pix
);

    hcfg_t                hcfg;
    vcfg_t                vcfg;
    pkt_desc_t            desc;
    line_kind_e           kind;
    step_e                step;
    logic [NUM_STEPS-1:0] mask;
    logic                 run_q, fire, line_done, frame_start, vse_line;

    assign hcfg = '{vc: cfg_vc, fmt: cfg_fmt, sync_pulse: cfg_sync_pulse,
                    burst: cfg_burst, hse: cfg_hse, skip_hsa: cfg_skip_hsa,
                    skip_hbp: cfg_skip_hbp, skip_hfp: cfg_skip_hfp,
                    eot_off: cfg_eot_off, hsa: cfg_hsa, hbp: cfg_hbp,
                    hfp: cfg_hfp, hpad: cfg_hpad, hact: cfg_hact};
    assign vcfg = '{auto_vert: cfg_auto_vert, vsa: cfg_vsa, vbp: cfg_vbp,
                    vfp: cfg_vfp, vact: cfg_vact};

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= en;
    end

    assign fire = run_q && pkt_ready;

    dsi_vseq_lines u_lines (
        .clk         (clk),
        .rst         (rst),
        .run         (run_q),
        .advance     (line_done),
        .vcfg        (vcfg),
        .kind        (kind),
        .frame_start (frame_start),
        .vse_line    (vse_line)
    );

    dsi_vseq_step u_step (
        .clk       (clk),
        .rst       (rst),
        .run       (run_q),
        .fire      (fire),
        .mask      (mask),
        .step      (step),
        .line_done (line_done)
    );

    dsi_vseq_plan u_plan (
        .hcfg        (hcfg),
        .kind        (kind),
        .frame_start (frame_start),
        .vse_line    (vse_line),
        .step        (step),
        .mask        (mask),
        .desc        (desc)
    );

    assign pkt_valid = run_q;
    assign pkt_di    = desc.di;
    assign pkt_wc    = desc.wc;
    assign pkt_pix   = desc.pix;

    // R1: a (re)started stream opens with VSYNC start
    p_open_vss_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(pkt_valid) |-> (pkt_di[5:0] == DT_VSS));

    // R13: a stalled descriptor stays put
    p_stall_stable_r13: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_ready && en) |=>
            (pkt_valid && $stable(pkt_di) && $stable(pkt_wc) && $stable(pkt_pix)));

    // R12: channel bits follow the configuration
    p_vc_field_r12: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (pkt_di[7:6] == cfg_vc));

    // R11: no end-of-transmission packet when suppressed
    p_no_eot_r11: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && cfg_eot_off) |-> (pkt_di[5:0] != DT_EOT));

    // R8: burst mode never pads with null packets
    p_no_null_r8: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && cfg_burst) |-> (pkt_di[5:0] != DT_NULL));

    // R5: sync-event mode never sends HSYNC end
    p_event_no_hse_r5: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !cfg_sync_pulse) |-> (pkt_di[5:0] != DT_HSE));

    // R10: the pixel flag only rides on pixel packets
    p_pix_type_r10: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_pix) |-> (pkt_di[3:0] == 4'hE));

endmodule

// File: tb/test_dsi_vid_pkt_seq.sv
`timescale 1ns/1ps
module test_dsi_vid_pkt_seq;

    logic        clk = 1'b0;
    logic        rst, en, pkt_ready;
    logic [1:0]  cfg_vc, cfg_fmt;
    logic        cfg_sync_pulse, cfg_burst, cfg_hse, cfg_skip_hsa, cfg_skip_hbp;
    logic        cfg_skip_hfp, cfg_eot_off, cfg_auto_vert;
    logic [15:0] cfg_hsa, cfg_hbp, cfg_hfp, cfg_hpad;
    logic [10:0] cfg_hact, cfg_vbp, cfg_vfp, cfg_vact;
    logic [9:0]  cfg_vsa;
    logic        pkt_valid, pkt_pix;
    logic [7:0]  pkt_di;
    logic [15:0] pkt_wc;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]  e_di  [256];
    logic [15:0] e_wc  [256];
    logic        e_pix [256];
    int          e_n;

    always #2.5 clk = ~clk;

    dsi_vid_pkt_seq i_dsi_vid_pkt_seq (
        .clk(clk), .rst(rst), .en(en),
        .cfg_vc(cfg_vc), .cfg_fmt(cfg_fmt), .cfg_sync_pulse(cfg_sync_pulse),
        .cfg_burst(cfg_burst), .cfg_hse(cfg_hse), .cfg_skip_hsa(cfg_skip_hsa),
        .cfg_skip_hbp(cfg_skip_hbp), .cfg_skip_hfp(cfg_skip_hfp),
        .cfg_eot_off(cfg_eot_off), .cfg_auto_vert(cfg_auto_vert),
        .cfg_hsa(cfg_hsa), .cfg_hbp(cfg_hbp), .cfg_hfp(cfg_hfp), .cfg_hpad(cfg_hpad),
        .cfg_hact(cfg_hact), .cfg_vsa(cfg_vsa), .cfg_vbp(cfg_vbp), .cfg_vfp(cfg_vfp),
        .cfg_vact(cfg_vact), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_di(pkt_di), .pkt_wc(pkt_wc), .pkt_pix(pkt_pix)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int bwc(input int bytes);
        return (bytes > 6) ? bytes - 6 : 0;
    endfunction

    task automatic push(input logic [5:0] dt, input int wc, input bit pix);
        e_di[e_n]  = {cfg_vc, dt};
        e_wc[e_n]  = 16'(wc);
        e_pix[e_n] = pix;
        e_n++;
    endtask

    // Expected packet list for one frame plus the opening packet of the next
    task automatic build_ref();
        int nl, a0, pwc;
        logic [5:0] pdt;
        nl = cfg_auto_vert ? int'(cfg_vact) + int'(cfg_vfp)
                           : int'(cfg_vsa) + int'(cfg_vbp) + int'(cfg_vact) + int'(cfg_vfp);
        a0 = cfg_auto_vert ? 0 : int'(cfg_vsa) + int'(cfg_vbp);
        case (cfg_fmt)
            2'd0: begin pdt = 6'h0E; pwc = 2 * int'(cfg_hact); end
            2'd1: begin pdt = 6'h1E; pwc = (9 * int'(cfg_hact) + 3) / 4; end
            2'd2: begin pdt = 6'h2E; pwc = 3 * int'(cfg_hact); end
            default: begin pdt = 6'h3E; pwc = 3 * int'(cfg_hact); end
        endcase
        e_n = 0;
        for (int l = 0; l < nl; l++) begin
            bit act;
            act = (l >= a0) && (l < a0 + int'(cfg_vact));
            if (l == 0) push(6'h01, 0, 0);
            else if (!cfg_auto_vert && l == int'(cfg_vsa)) push(6'h11, 0, 0);
            else push(6'h21, 0, 0);
            if (act) begin
                if (cfg_sync_pulse && !cfg_skip_hsa) push(6'h19, bwc(int'(cfg_hsa)), 0);
                if (cfg_sync_pulse) push(6'h31, 0, 0);
                if (!cfg_skip_hbp) push(6'h19, bwc(int'(cfg_hbp)), 0);
                push(pdt, pwc, 1);
                if (!cfg_burst) push(6'h09, bwc(int'(cfg_hpad)), 0);
                if (!cfg_skip_hfp) push(6'h19, bwc(int'(cfg_hfp)), 0);
            end else if (cfg_sync_pulse && cfg_hse) begin
                push(6'h31, 0, 0);
            end
            if (!cfg_eot_off) push(6'h08, 0, 0);
        end
        push(6'h01, 0, 0);
    endtask

    task automatic set_base();
        cfg_vc = 2'd0; cfg_fmt = 2'd3; cfg_sync_pulse = 1'b1; cfg_burst = 1'b0;
        cfg_hse = 1'b0; cfg_skip_hsa = 1'b0; cfg_skip_hbp = 1'b0; cfg_skip_hfp = 1'b0;
        cfg_eot_off = 1'b0; cfg_auto_vert = 1'b0;
        cfg_hsa = 16'd10; cfg_hbp = 16'd5; cfg_hfp = 16'd20; cfg_hpad = 16'd8;
        cfg_hact = 11'd4; cfg_vsa = 10'd2; cfg_vbp = 11'd1; cfg_vact = 11'd3; cfg_vfp = 11'd2;
    endtask

    // Runs one frame from a fresh start and compares every accepted descriptor
    task automatic run_frame(input string req, input bit stall);
        int got, cyc;
        bit held;
        logic [7:0]  s_di;
        logic [15:0] s_wc;
        logic        s_pix;
        build_ref();
        en = 1'b1;
        got = 0; cyc = 0; held = 0;
        s_di = '0; s_wc = '0; s_pix = 1'b0;
        while (got < e_n) begin
            @(negedge clk);
            cyc++;
            if (held) begin
                check(pkt_valid && pkt_di == s_di && pkt_wc == s_wc && pkt_pix == s_pix,
                      "R13", "stalled descriptor", {pkt_di, pkt_wc}, {s_di, s_wc});
            end
            held = 0;
            pkt_ready = stall ? (cyc % 3 != 1) : 1'b1;
            if (pkt_valid && pkt_ready) begin
                check(pkt_di == e_di[got], req, $sformatf("di #%0d", got), pkt_di, e_di[got]);
                check(pkt_wc == e_wc[got], req, $sformatf("wc #%0d", got), pkt_wc, e_wc[got]);
                check(pkt_pix == e_pix[got], req, $sformatf("pix #%0d", got), pkt_pix, e_pix[got]);
                got++;
            end else if (pkt_valid) begin
                s_di = pkt_di; s_wc = pkt_wc; s_pix = pkt_pix;
                held = 1;
            end
        end
        pkt_ready = 1'b1;
        en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 1'b1; pkt_ready = 1'b1;
        set_base();
        repeat (3) @(negedge clk);
        check(pkt_valid == 1'b0, "R1", "valid in reset", pkt_valid, 0);
        rst = 1'b0; en = 1'b0;
        repeat (2) @(negedge clk);
        check(pkt_valid == 1'b0, "R1", "valid with en low", pkt_valid, 0);
    endtask

    task automatic t_pulse_frame();
        set_base();
        run_frame("R2/R3/R5/R8/R9/R10", 0);
    endtask

    task automatic t_event_burst();
        set_base();
        cfg_sync_pulse = 1'b0; cfg_hse = 1'b1; cfg_burst = 1'b1;
        cfg_vc = 2'd2; cfg_fmt = 2'd2;
        run_frame("R5/R6/R8/R10/R12", 0);
    endtask

    task automatic t_skip_hse();
        set_base();
        cfg_hse = 1'b1; cfg_skip_hsa = 1'b1; cfg_skip_hbp = 1'b1; cfg_skip_hfp = 1'b1;
        cfg_eot_off = 1'b1; cfg_fmt = 2'd1; cfg_vc = 2'd1;
        run_frame("R6/R7/R10/R11", 0);
        set_base();
        cfg_skip_hbp = 1'b1; cfg_hpad = 16'd3;
        run_frame("R7/R9", 0);
    endtask

    task automatic t_auto_stall();
        set_base();
        cfg_auto_vert = 1'b1; cfg_fmt = 2'd0; cfg_vact = 11'd2;
        run_frame("R4/R10/R13", 1);
    endtask

    task automatic t_restart();
        set_base();
        pkt_ready = 1'b1;
        en = 1'b1;
        repeat (6) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(pkt_valid == 1'b0, "R1", "valid after en drop", pkt_valid, 0);
        en = 1'b1;
        @(negedge clk);
        check(pkt_valid == 1'b1, "R1", "valid after restart", pkt_valid, 1);
        check(pkt_di == 8'h01, "R1", "restart opens with VSS", pkt_di, 8'h01);
        en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_pulse_frame();
        t_event_burst();
        t_skip_hse();
        t_auto_stall();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule